// File: doc/BRIEF.md
# Masked-Write GPIO Bank with Pad Muxing

This block is a bank of up to 32 general-purpose pins that software controls through a small word-addressed register bus. The pins are grouped into 16-pin slices. Each slice has two control words, one for direction and one for output level. A bank built with per-pin muxing has a third word per slice that chooses, pin by pin, between software control and a primary hardware function. A bank built with group muxing instead has one plain word placed ahead of all slices, and that word moves the whole bank between the two owners. A bank built with no mux has its pins under software control at all times.

Every slice control word uses a masked-write format. The upper half-word of the write data selects which bits change, and the lower half-word gives their new values. Software can therefore flip one pin without first reading the word back. A pin in software mode takes its output enable and output level from the direction and value words. A pin in primary mode takes both from the `prim_oe` and `prim_out` inputs. The pad inputs pass through a two-flop synchronizer before software can read them.

The register bus has no handshake. A write takes effect at the clock edge where `reg_we` is high. `reg_rdata` is combinational from `reg_addr` and the current state. The bus is a plain control interface, so it has no back-pressure.

Top module: `gpiob_bank`

## Requirements
- R1: A write to a direction, value or per-pin mux word changes exactly those data bits [15:0] whose mask bit (bit index + 16) is 1 in the write data. All other bits keep their values.
- R2: Pin n belongs to slice n/16 and uses data bit n%16 and mask bit n%16+16 of that slice's words. Example: pin 20 uses bit 4 and mask bit 20 of slice 1.
- R3: Reading a masked word returns its 16 data bits in [15:0] and zero in [31:16].
- R4: In software mode a direction bit of 1 makes the pin an output: `pad_oe` is 1 and `pad_out` equals the value bit. A direction bit of 0 gives `pad_oe` = 0.
- R5: For a pin whose direction bit is 1, reading the value word returns the driven value bit. For a pin whose direction bit is 0, it returns the pad input level after two synchronizing flops. A change on `pad_in` becomes readable after the second rising edge and not after the first.
- R6: In primary mode `pad_oe` and `pad_out` follow `prim_oe` and `prim_out`, whatever the direction and value words hold.
- R7: With per-pin muxing (MUX_KIND = 1), slice s occupies words 3s (direction), 3s+1 (value) and 3s+2 (mux). A mux bit of 1 puts its pin in software mode, and 0 puts it in primary mode.
- R8: With group muxing (MUX_KIND = 2), word 0 is a plain 32-bit register and slice s occupies words 1+2s (direction) and 2+2s (value). The value 0x6 puts all pins in software mode. Any other value, including 0x1, puts them in primary mode. Word 0 reads back as written.
- R9: After reset all direction, value and mux bits are 0, and the group word holds 0x1.
- R10: A value bit written while its pin is still an input is on `pad_out` in the same cycle that `pad_oe` first rises after the direction write.
- R11: With no mux (MUX_KIND = 0), slice s occupies words 2s and 2s+1, and every pin stays in software mode regardless of the primary inputs.
- R12: A write to an address outside the map changes no state. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| reg_addr | input | ADDR_W | Word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data (mask in [31:16] for masked words) |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| prim_oe | input | NUM_PINS | Primary-function output enable per pin |
| prim_out | input | NUM_PINS | Primary-function output level per pin |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_out | output | NUM_PINS | Pad output level |

## Verification
Three banks are built, one for each mux option. Each bank is driven with its own address layout, so a stride or base offset that is wrong shows up as a wrong pin moving. Masked writes use a mask that partly overlaps the data and then a mask narrower than the data, which separates correct masking from plain overwrite and from OR-ing. The primary inputs take an all-zero pattern and then a mixed pattern with one software pin set inside the range. This shows that the mux chooses per pin rather than per slice. A pad input edge is sampled one edge and then two edges later to pin down the synchronizer depth, while an output pin with a high pad input shows that the readback chooses by direction.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;

  typedef enum logic [1:0] {
    MUXSEL_NONE  = 2'd0,
    MUXSEL_PIN   = 2'd1,
    MUXSEL_GROUP = 2'd2
  } mux_kind_e;

  localparam int          SLICE_W  = 16;
  localparam logic [31:0] GRP_GPIO = 32'h0000_0006;
  localparam logic [31:0] GRP_PRIM = 32'h0000_0001;

  function automatic int slice_stride(mux_kind_e k);
    return (k == MUXSEL_PIN) ? 3 : 2;
  endfunction

  function automatic int map_base(mux_kind_e k);
    return (k == MUXSEL_GROUP) ? 1 : 0;
  endfunction

endpackage

// File: rtl/gpiob_masked_reg.sv
module gpiob_masked_reg #(
  parameter int LIVE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_word,
  output logic [15:0] q
);
  localparam logic [15:0] LIVE_MASK = 16'((33'd1 << LIVE) - 33'd1);

  logic [15:0] eff_mask;
  assign eff_mask = wr_word[31:16] & LIVE_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= (q & ~eff_mask) | (wr_word[15:0] & eff_mask);
  end

  // R1: unmasked bits never move on a write
  assert_unmasked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~$past(wr_word[31:16])) == 16'h0));

  // R12: without a write strobe the word is frozen
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/gpiob_sync.sv
module gpiob_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  logic [1:0]   warm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R5: input is seen exactly two edges later
  assert_two_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpiob_slice.sv
module gpiob_slice
  import gpiob_pkg::*;
#(
  parameter mux_kind_e MUX_KIND = MUXSEL_PIN,
  parameter int        LIVE     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_dir,
  input  logic        we_val,
  input  logic        we_mux,
  input  logic [31:0] wr_word,
  input  logic        grp_gpio,
  input  logic [15:0] pin_sync,
  input  logic [15:0] prim_oe,
  input  logic [15:0] prim_out,
  output logic [15:0] pad_oe,
  output logic [15:0] pad_out,
  output logic [15:0] dir_q,
  output logic [15:0] val_rd,
  output logic [15:0] mux_q
);
  logic [15:0] val_q;
  logic [15:0] sel_sw;

  gpiob_masked_reg #(.LIVE(LIVE)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_en(we_dir), .wr_word(wr_word), .q(dir_q));

  gpiob_masked_reg #(.LIVE(LIVE)) u_val (
    .clk(clk), .rst_n(rst_n), .wr_en(we_val), .wr_word(wr_word), .q(val_q));

  // Always present; its strobe is only decoded in per-pin mux builds.
  gpiob_masked_reg #(.LIVE(LIVE)) u_mux (
    .clk(clk), .rst_n(rst_n), .wr_en(we_mux), .wr_word(wr_word), .q(mux_q));

  always_comb begin
    if (MUX_KIND == MUXSEL_NONE)     sel_sw = '1;
    else if (MUX_KIND == MUXSEL_PIN) sel_sw = mux_q;
    else                             sel_sw = {16{grp_gpio}};
  end

  assign pad_oe  = (sel_sw & dir_q) | (~sel_sw & prim_oe);
  assign pad_out = (sel_sw & val_q) | (~sel_sw & prim_out);
  assign val_rd  = (dir_q & val_q)  | (~dir_q & pin_sync);

  for (genvar i = 0; i < LIVE; i++) begin : g_chk
    // R4: a direction write in software mode lands on the pad enable
    assert_dir_to_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(we_dir) && $past(wr_word[16+i]) && sel_sw[i] && $past(sel_sw[i]))
        |-> (pad_oe[i] == $past(wr_word[i])));
    // R6: in primary mode a quiet primary enable keeps the pad quiet
    assert_prim_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_sw[i] && !$past(sel_sw[i]) && $stable(prim_oe[i]))
        |-> $stable(pad_oe[i]));
  end

endmodule

// File: rtl/gpiob_bank.sv
module gpiob_bank
  import gpiob_pkg::*;
#(
  parameter int        NUM_PINS = 32,
  parameter mux_kind_e MUX_KIND = MUXSEL_PIN,
  parameter int        ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] prim_oe,
  input  logic [NUM_PINS-1:0] prim_out,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);
  localparam int SLICES = (NUM_PINS + SLICE_W - 1) / SLICE_W;
  localparam int PADW   = SLICES * SLICE_W;
  localparam int BASE   = map_base(MUX_KIND);
  localparam int STRIDE = slice_stride(MUX_KIND);

  logic [PADW-1:0] prim_oe_x, prim_out_x, sync_x, oe_x, out_x;
  logic [NUM_PINS-1:0] pin_sync;

  logic [SLICES-1:0]        we_dir, we_val, we_mux;
  logic [SLICES-1:0][15:0]  dir_q, val_rd, mux_q;
  logic                     we_grp, hit, hit_masked;
  logic [31:0]              grp_q;
  logic                     grp_gpio;

  gpiob_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync));

  assign prim_oe_x  = PADW'(prim_oe);
  assign prim_out_x = PADW'(prim_out);
  assign sync_x     = PADW'(pin_sync);

  always_comb begin
    we_dir     = '0;
    we_val     = '0;
    we_mux     = '0;
    we_grp     = 1'b0;
    hit        = 1'b0;
    hit_masked = 1'b0;
    reg_rdata  = '0;
    if (MUX_KIND == MUXSEL_GROUP && int'(reg_addr) == 0) begin
      hit       = 1'b1;
      we_grp    = reg_we;
      reg_rdata = grp_q;
    end
    for (int s = 0; s < SLICES; s++) begin
      if (int'(reg_addr) == BASE + STRIDE*s) begin
        hit        = 1'b1;
        hit_masked = 1'b1;
        we_dir[s]  = reg_we;
        reg_rdata  = {16'h0, dir_q[s]};
      end
      if (int'(reg_addr) == BASE + STRIDE*s + 1) begin
        hit        = 1'b1;
        hit_masked = 1'b1;
        we_val[s]  = reg_we;
        reg_rdata  = {16'h0, val_rd[s]};
      end
      if (MUX_KIND == MUXSEL_PIN && int'(reg_addr) == BASE + STRIDE*s + 2) begin
        hit        = 1'b1;
        hit_masked = 1'b1;
        we_mux[s]  = reg_we;
        reg_rdata  = {16'h0, mux_q[s]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      grp_q <= GRP_PRIM;
    else if (we_grp) grp_q <= reg_wdata;
  end

  assign grp_gpio = (MUX_KIND == MUXSEL_GROUP) && (grp_q == GRP_GPIO);

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    localparam int LIVE = (NUM_PINS - SLICE_W*s) < SLICE_W ? (NUM_PINS - SLICE_W*s) : SLICE_W;
    gpiob_slice #(.MUX_KIND(MUX_KIND), .LIVE(LIVE)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_dir   (we_dir[s]),
      .we_val   (we_val[s]),
      .we_mux   (we_mux[s]),
      .wr_word  (reg_wdata),
      .grp_gpio (grp_gpio),
      .pin_sync (sync_x[SLICE_W*s +: SLICE_W]),
      .prim_oe  (prim_oe_x[SLICE_W*s +: SLICE_W]),
      .prim_out (prim_out_x[SLICE_W*s +: SLICE_W]),
      .pad_oe   (oe_x[SLICE_W*s +: SLICE_W]),
      .pad_out  (out_x[SLICE_W*s +: SLICE_W]),
      .dir_q    (dir_q[s]),
      .val_rd   (val_rd[s]),
      .mux_q    (mux_q[s])
    );
  end

  assign pad_oe  = oe_x[NUM_PINS-1:0];
  assign pad_out = out_x[NUM_PINS-1:0];

  // R3: masked words never show anything in the mask half
  assert_mask_half_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_masked |-> (reg_rdata[31:16] == 16'h0));

  // R12: holes in the map read as zero
  assert_hole_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (reg_rdata == 32'h0));

  if (MUX_KIND == MUXSEL_GROUP) begin : g_grp_chk
    // R8: writing the software code hands the bank to software
    assert_grp_to_sw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && int'(reg_addr) == 0 && reg_wdata == GRP_GPIO) |=> grp_gpio);
    // R8: any other code hands it to the primary function
    assert_grp_to_prim_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && int'(reg_addr) == 0 && reg_wdata != GRP_GPIO) |=> !grp_gpio);
  end

endmodule

// File: tb/gpiob_bank_tb_top.sv
`timescale 1ns/1ps
module gpiob_bank_tb_top;
  import gpiob_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  we = '0;
  logic [31:0] rd_p, rd_g, rd_n;
  logic [31:0] prim_oe = '0, prim_out = '0, pad_in = '0;
  logic [31:0] oe_p, out_p, oe_g, out_g, oe_n, out_n;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpiob_bank #(.NUM_PINS(32), .MUX_KIND(MUXSEL_PIN), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we[0]), .reg_wdata(wdata),
    .reg_rdata(rd_p), .prim_oe(prim_oe), .prim_out(prim_out), .pad_in(pad_in),
    .pad_oe(oe_p), .pad_out(out_p));

  gpiob_bank #(.NUM_PINS(32), .MUX_KIND(MUXSEL_GROUP), .ADDR_W(4)) dut_grp_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we[1]), .reg_wdata(wdata),
    .reg_rdata(rd_g), .prim_oe(prim_oe), .prim_out(prim_out), .pad_in(pad_in),
    .pad_oe(oe_g), .pad_out(out_g));

  gpiob_bank #(.NUM_PINS(32), .MUX_KIND(MUXSEL_NONE), .ADDR_W(4)) dut_none_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we[2]), .reg_wdata(wdata),
    .reg_rdata(rd_n), .prim_oe(prim_oe), .prim_out(prim_out), .pad_in(pad_in),
    .pad_oe(oe_n), .pad_out(out_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int unit, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a;
    wdata = d;
    we[unit] = 1'b1;
    @(negedge clk);
    we = '0;
  endtask

  task automatic bus_rd(input int unit, input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = (unit == 0) ? rd_p : (unit == 1) ? rd_g : rd_n;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      bus_rd(0, 4'(a), v);
      check("R9 pin-bank word after reset", v, 32'h0);
    end
    bus_rd(1, 4'd0, v);
    check("R9 group word after reset", v, 32'h1);
    check("R9 pad_oe after reset", oe_p | oe_g | oe_n, 32'h0);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    bus_wr(0, 4'd0, 32'h00FF_00A5);
    bus_rd(0, 4'd0, v);
    check("R1 partial mask", v, 32'h0000_00A5);
    bus_wr(0, 4'd0, 32'h0003_FFFF);
    bus_rd(0, 4'd0, v);
    check("R1 R3 narrow mask, upper half zero", v, 32'h0000_00A7);
  endtask

  task automatic t_input_sync();
    logic [31:0] v;
    pad_in = 32'h0000_0009;
    @(posedge clk); @(negedge clk);
    bus_rd(0, 4'd1, v);
    check("R5 one edge after input change", v, 32'h0);
    @(posedge clk); @(negedge clk);
    bus_rd(0, 4'd1, v);
    check("R5 two edges: input pin 3 high, output pin 0 reads value", v, 32'h0000_0008);
  endtask

  task automatic t_pin_mux();
    bus_wr(0, 4'd4, 32'h0010_0010);
    bus_wr(0, 4'd5, 32'h0010_0010);
    check("R7 pin 20 software mode, still input", oe_p, 32'h0);
    bus_wr(0, 4'd3, 32'h0010_0010);
    check("R2 R4 pin 20 output enable", oe_p, 32'h0010_0000);
    check("R10 R2 preloaded level on first enabled cycle", out_p, 32'h0010_0000);
    @(negedge clk);
    prim_oe = 32'hFFFF_FFFF;
    prim_out = 32'h1224_5678;
    #1;
    check("R6 primary enables with pin 20 in software", oe_p, 32'hFFFF_FFFF);
    check("R6 R7 primary data with pin 20 in software", out_p, 32'h1234_5678);
    prim_oe = 32'h0;
    #1;
    check("R6 primary enables dropped", oe_p, 32'h0010_0000);
  endtask

  task automatic t_hole();
    logic [31:0] v;
    bus_wr(0, 4'd9, 32'hFFFF_FFFF);
    bus_rd(0, 4'd9, v);
    check("R12 hole reads zero", v, 32'h0);
    bus_rd(0, 4'd0, v);
    check("R12 direction untouched by hole write", v, 32'h0000_00A7);
    check("R12 pads untouched by hole write", oe_p, 32'h0010_0000);
  endtask

  task automatic t_group();
    logic [31:0] v;
    bus_wr(1, 4'd1, 32'h0001_0001);
    bus_wr(1, 4'd2, 32'h0001_0001);
    check("R8 group primary keeps pin 0 off", oe_g, 32'h0);
    bus_wr(1, 4'd0, 32'h0000_0006);
    check("R8 group software enables", oe_g, 32'h0000_0001);
    check("R8 group software data", out_g[0], 1'b1);
    bus_rd(1, 4'd0, v);
    check("R8 group word readback", v, 32'h6);
    bus_wr(1, 4'd0, 32'h0000_0003);
    check("R8 other code means primary", oe_g, 32'h0);
    bus_wr(1, 4'd0, 32'h0000_0001);
    check("R8 code 1 means primary", out_g, 32'h1224_5678);
  endtask

  task automatic t_none();
    @(negedge clk);
    prim_oe = 32'hFFFF_FFFF;
    bus_wr(2, 4'd2, 32'h8000_8000);
    bus_wr(2, 4'd3, 32'h8000_0000);
    check("R11 no-mux pads ignore primary enable", oe_n, 32'h8000_0000);
    check("R11 no-mux pads ignore primary data", out_n, 32'h0);
  endtask

  initial begin
    #(200000 * 8);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_input_sync();
    t_pin_mux();
    t_hole();
    t_group();
    t_none();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule